// File: doc/BRIEF.md
# Interrupt Message Vector Fetcher

This block takes in 32-bit interrupt messages that reach it as writes on a response bus. It keeps the messages in a short queue and takes them out one at a time. For each message it extracts a target controller number, a vector number and a priority. A message whose controller number differs from this controller's identity is discarded without any trace.

For a message that does match, the block forms the address of a 256-bit vector-table entry in system RAM. The address is the programmed table base plus 32 bytes for each vector number. A vector whose byte offset reaches or passes the programmed table length is discarded, and a sticky range-error flag is raised. A vector that lies inside the table causes one wide memory read. When the entry returns, it goes to a downstream dispatcher in a single-cycle pulse, together with the vector number and the priority. The entry holds, among other things, a 64-bit pool mask of eligible cores and a 96-bit instruction/address field. The block passes the entry through without interpreting it.

The fetch sequencer has four named states:
- `S_IDLE` waits for a queued message. It pops each message and inspects it. A matching, in-range message causes transition *accept* to `S_REQ`. Any other message stays in `S_IDLE` through transition *discard*.
- `S_REQ` holds the read request. Transition *granted* moves it to `S_WAIT` when the memory accepts.
- `S_WAIT` waits for the read data. Transition *returned* moves it to `S_SEND`.
- `S_SEND` drives the dispatch pulse. Transition *done* returns it to `S_IDLE` unconditionally.

Top module: `msi_vec_fetch`

## Requirements
- R1: The message fields are as follows. Bits [11:0] are the vector number. Bits [17:12] are the target controller number. Bits [23:18] are the priority. Bits [31:24] have no effect on any output.
- R2: A message whose bits [17:12] differ from `ctrl_id` produces no memory request and no dispatch. It leaves `range_err` unchanged, even when its vector would also be out of range.
- R3: The read address for an accepted message is `table_base + vector*32`, computed modulo 2^32.
- R4: A matching message whose offset `vector*32` is greater than or equal to `table_len` produces no request and no dispatch. It sets `range_err`, which stays at 1 until reset.
- R5: Up to four messages can wait in the queue while the sequencer is busy with another message. `msg_ready` is low only while the queue holds four. No accepted message is lost, and messages are dispatched in arrival order.
- R6: At most one read is in flight. `mem_req_valid` stays high with a stable address until `mem_req_ready`. No new request is issued before the response returns.
- R7: The cycle after `mem_rsp_valid`, `disp_valid` is high for exactly one cycle. It carries the returned 256 bits, the message's vector and the message's priority.
- R8: After reset, the following hold: `msg_ready`=1, `mem_req_valid`=0, `disp_valid`=0, `range_err`=0, and both table registers are 0.
- R9: When `cfg_we` is high, `cfg_wdata` is written to the table base if `cfg_sel`=0, or to the table length if `cfg_sel`=1. With a length of 0, every matching message is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_id | input | 6 | This controller's identity number |
| cfg_we | input | 1 | Table register write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects table length |
| cfg_wdata | input | 32 | Table register write data |
| msg_valid | input | 1 | Incoming message present |
| msg_ready | output | 1 | Queue can take a message |
| msg_data | input | 32 | Incoming message payload |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 256 | Table entry returned by memory |
| disp_valid | output | 1 | One-cycle dispatch pulse |
| disp_vector | output | 12 | Vector number of the dispatched entry |
| disp_prio | output | 6 | Priority of the dispatched entry |
| disp_entry | output | 256 | Fetched table entry |
| range_err | output | 1 | Sticky out-of-range flag |

## Verification
The properties assume the memory side behaves well. `mem_rsp_valid` arrives only after a granted request and lasts for a single cycle. The table registers do not change while a message is being fetched. The bench follows these rules with its memory model, which answers each granted read exactly once, one cycle after the grant. All table writes happen before any message is sent. Back-pressure is produced by holding `mem_req_ready` low in the bench and never by reordering or duplicating responses.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam int VEC_W   = 12;
    localparam int ID_W    = 6;
    localparam int PRIO_W  = 6;
    localparam int FIELD_W = VEC_W + ID_W + PRIO_W;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   ctrl;
        logic [VEC_W-1:0]  vec;
    } msi_fields_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_SEND
    } fetch_state_t;
endpackage

// File: rtl/msi_msg_fifo.sv
module msi_msg_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 24,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                slots[wptr] <= wdata;
                wptr        <= bump(wptr);
            end
            if (pop) rptr <= bump(rptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign rdata = slots[rptr];
endmodule

// File: rtl/msi_msg_decode.sv
module msi_msg_decode
    import msi_pkg::*;
#(
    parameter int AW          = 32,
    parameter int ENTRY_BYTES = 32,
    localparam int SHIFT = $clog2(ENTRY_BYTES)
) (
    input  logic [FIELD_W-1:0] fields,
    input  logic [ID_W-1:0]    own_id,
    input  logic [AW-1:0]      base,
    input  logic [AW-1:0]      len,
    output logic [VEC_W-1:0]   vec,
    output logic [PRIO_W-1:0]  prio,
    output logic               id_match,
    output logic               in_range,
    output logic [AW-1:0]      addr
);
    msi_fields_t f;
    logic [AW-1:0] offset;

    assign f        = msi_fields_t'(fields);
    assign vec      = f.vec;
    assign prio     = f.prio;
    assign id_match = (f.ctrl == own_id);
    assign offset   = AW'(f.vec) << SHIFT;
    assign in_range = (offset < len);
    assign addr     = base + offset;
endmodule

// File: rtl/msi_fetch_fsm.sv
module msi_fetch_fsm
    import msi_pkg::*;
#(
    parameter int AW      = 32,
    parameter int ENTRY_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               id_match,
    input  logic               in_range,
    input  logic [VEC_W-1:0]   dec_vec,
    input  logic [PRIO_W-1:0]  dec_prio,
    input  logic [AW-1:0]      dec_addr,
    output logic               pop,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [AW-1:0]      mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               disp_valid,
    output logic [VEC_W-1:0]   disp_vector,
    output logic [PRIO_W-1:0]  disp_prio,
    output logic [ENTRY_W-1:0] disp_entry,
    output logic               range_err
);
    fetch_state_t state, state_nx;
    logic [VEC_W-1:0]   vec_q;
    logic [PRIO_W-1:0]  prio_q;
    logic [AW-1:0]      addr_q;
    logic [ENTRY_W-1:0] entry_q;
    logic               take;

    assign take = in_valid && id_match && in_range;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (take)          state_nx = S_REQ;
            S_REQ:  if (mem_req_ready) state_nx = S_WAIT;
            S_WAIT: if (mem_rsp_valid) state_nx = S_SEND;
            S_SEND:                    state_nx = S_IDLE;
            default:                   state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        pop           = 1'b0;
        mem_req_valid = 1'b0;
        disp_valid    = 1'b0;
        unique case (state)
            S_IDLE:  pop           = in_valid;
            S_REQ:   mem_req_valid = 1'b1;
            S_WAIT:  ;
            S_SEND:  disp_valid    = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q     <= '0;
            prio_q    <= '0;
            addr_q    <= '0;
            entry_q   <= '0;
            range_err <= 1'b0;
        end else begin
            if (state == S_IDLE && take) begin
                vec_q  <= dec_vec;
                prio_q <= dec_prio;
                addr_q <= dec_addr;
            end
            if (state == S_IDLE && in_valid && id_match && !in_range)
                range_err <= 1'b1;
            if (state == S_WAIT && mem_rsp_valid)
                entry_q <= mem_rsp_data;
        end
    end

    assign mem_req_addr = addr_q;
    assign disp_vector  = vec_q;
    assign disp_prio    = prio_q;
    assign disp_entry   = entry_q;
endmodule

// File: rtl/msi_vec_fetch.sv
module msi_vec_fetch
    import msi_pkg::*;
#(
    parameter int AW          = 32,
    parameter int MSG_W       = 32,
    parameter int ENTRY_W     = 256,
    parameter int ENTRY_BYTES = ENTRY_W / 8,
    parameter int QDEPTH      = 4,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    ctrl_id,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [AW-1:0]      cfg_wdata,
    input  logic               msg_valid,
    output logic               msg_ready,
    input  logic [MSG_W-1:0]   msg_data,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [AW-1:0]      mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               disp_valid,
    output logic [VEC_W-1:0]   disp_vector,
    output logic [PRIO_W-1:0]  disp_prio,
    output logic [ENTRY_W-1:0] disp_entry,
    output logic               range_err
);
    logic [AW-1:0]      base_q, len_q;
    logic [CNT_W-1:0]   fifo_cnt;
    logic [FIELD_W-1:0] head;
    logic               pop, have_msg, unused_rsvd;
    logic [VEC_W-1:0]   d_vec;
    logic [PRIO_W-1:0]  d_prio;
    logic               d_match, d_range;
    logic [AW-1:0]      d_addr;

    assign unused_rsvd = ^msg_data[MSG_W-1:FIELD_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) len_q  <= cfg_wdata;
            else         base_q <= cfg_wdata;
        end
    end

    assign msg_ready = (fifo_cnt != CNT_W'(QDEPTH));
    assign have_msg  = (fifo_cnt != '0);

    msi_msg_fifo #(.DEPTH(QDEPTH), .W(FIELD_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (msg_valid && msg_ready),
        .wdata (msg_data[FIELD_W-1:0]),
        .pop   (pop),
        .rdata (head),
        .count (fifo_cnt)
    );

    msi_msg_decode #(.AW(AW), .ENTRY_BYTES(ENTRY_BYTES)) u_dec (
        .fields   (head),
        .own_id   (ctrl_id),
        .base     (base_q),
        .len      (len_q),
        .vec      (d_vec),
        .prio     (d_prio),
        .id_match (d_match),
        .in_range (d_range),
        .addr     (d_addr)
    );

    msi_fetch_fsm #(.AW(AW), .ENTRY_W(ENTRY_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (have_msg),
        .id_match      (d_match),
        .in_range      (d_range),
        .dec_vec       (d_vec),
        .dec_prio      (d_prio),
        .dec_addr      (d_addr),
        .pop           (pop),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .disp_valid    (disp_valid),
        .disp_vector   (disp_vector),
        .disp_prio     (disp_prio),
        .disp_entry    (disp_entry),
        .range_err     (range_err)
    );
endmodule

// File: rtl/msi_vec_fetch_chk.sv
module msi_vec_fetch_chk #(
    parameter int AW     = 32,
    parameter int QDEPTH = 4,
    parameter int CNT_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [AW-1:0]    mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             disp_valid,
    input logic             range_err,
    input logic [AW-1:0]    base_q,
    input logic [AW-1:0]    len_q,
    input logic [CNT_W-1:0] fifo_cnt
);
    logic in_flight;

    always_ff @(posedge clk) begin
        if (!rst_n)                             in_flight <= 1'b0;
        else if (mem_req_valid && mem_req_ready) in_flight <= 1'b1;
        else if (mem_rsp_valid)                  in_flight <= 1'b0;
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(QDEPTH));

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (fifo_cnt <= $past(fifo_cnt)));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight |-> !mem_req_valid);

    // R7
    disp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !disp_valid);

    // R7
    disp_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_valid) |-> $past(mem_rsp_valid));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |=> range_err);

    // R4
    req_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ((mem_req_addr - base_q) < len_q));
endmodule

bind msi_vec_fetch msi_vec_fetch_chk #(.AW(AW), .QDEPTH(QDEPTH), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .msg_valid     (msg_valid),
    .msg_ready     (msg_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .disp_valid    (disp_valid),
    .range_err     (range_err),
    .base_q        (base_q),
    .len_q         (len_q),
    .fifo_cnt      (fifo_cnt)
);

// File: tb/msi_vec_fetch_test.sv
module msi_vec_fetch_test;
    logic         clk, rst_n;
    logic [5:0]   ctrl_id;
    logic         cfg_we, cfg_sel;
    logic [31:0]  cfg_wdata;
    logic         msg_valid, msg_ready;
    logic [31:0]  msg_data;
    logic         mem_req_valid, mem_req_ready;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid;
    logic [255:0] mem_rsp_data;
    logic         disp_valid;
    logic [11:0]  disp_vector;
    logic [5:0]   disp_prio;
    logic [255:0] disp_entry;
    logic         range_err;

    msi_vec_fetch uut (
        .clk(clk), .rst_n(rst_n), .ctrl_id(ctrl_id),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .disp_valid(disp_valid),
        .disp_vector(disp_vector), .disp_prio(disp_prio),
        .disp_entry(disp_entry), .range_err(range_err)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    localparam logic [31:0] BASE = 32'h8000_0400;
    localparam logic [31:0] LEN  = 32'd2048;

    // {message, expect dispatch, expected range_err afterwards}
    localparam logic [33:0] TV [7] = '{
        {32'h000C_5000, 2'b10},
        {32'h00FC_503F, 2'b10},
        {32'h0004_6001, 2'b00},
        {32'h0000_0FFF, 2'b00},
        {32'hFF28_5011, 2'b10},
        {32'h0008_5040, 2'b01},
        {32'h0004_5021, 2'b11}
    };

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit mem_open = 1;
    int req_count = 0, disp_count = 0;
    logic [31:0]  req_addr [64];
    logic [11:0]  cap_vec  [64];
    logic [5:0]   cap_prio [64];
    logic [255:0] cap_ent  [64];

    assign mem_req_ready = mem_open;

    function automatic logic [255:0] entry_of(input logic [31:0] a);
        return {4{a, ~a}} ^ {8{32'h1357_9BDF}};
    endfunction

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; msg_valid = 1'b0; cfg_we = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic write_cfg(input logic sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        idle(1);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] d);
        msg_data = d; msg_valid = 1'b1;
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    // memory model: one response, one cycle after each granted read
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk); #2;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                req_addr[req_count % 64] = mem_req_addr;
                req_count++;
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = entry_of(mem_req_addr);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && disp_valid) begin
            cap_vec [disp_count % 64] = disp_vector;
            cap_prio[disp_count % 64] = disp_prio;
            cap_ent [disp_count % 64] = disp_entry;
            disp_count++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        ctrl_id = 6'd5; cfg_sel = 1'b0; cfg_wdata = '0; msg_data = '0;
        do_reset();

        // R8 reset state
        chk("R8 msg_ready", msg_ready, 1);
        chk("R8 mem_req_valid", mem_req_valid, 0);
        chk("R8 disp_valid", disp_valid, 0);
        chk("R8 range_err", range_err, 0);

        // R9 length resets to 0: every matching message is out of range
        begin
            int r0, d0;
            r0 = req_count; d0 = disp_count;
            send(32'h0000_5000);
            idle(12);
            chk("R9 zero length sets range_err", range_err, 1);
            chk("R9 zero length no request", req_count - r0, 0);
            chk("R9 zero length no dispatch", disp_count - d0, 0);
        end

        do_reset();
        chk("R8 range_err cleared by reset", range_err, 0);

        write_cfg(1'b0, BASE);
        write_cfg(1'b1, LEN);

        // table of messages: R1 R2 R3 R4 R7
        for (int i = 0; i < 7; i++) begin
            logic [31:0] m;
            logic        acc, err;
            int          r0, d0;
            m = TV[i][33:2]; acc = TV[i][1]; err = TV[i][0];
            r0 = req_count; d0 = disp_count;
            send(m);
            idle(12);
            chk($sformatf("R2/R4 dispatch count msg %0d", i), disp_count - d0, acc ? 1 : 0);
            chk($sformatf("R2/R4 request count msg %0d", i), req_count - r0, acc ? 1 : 0);
            chk($sformatf("R4 range_err after msg %0d", i), range_err, err);
            if (acc) begin
                chk($sformatf("R1 vector msg %0d", i), cap_vec[d0 % 64], m[11:0]);
                chk($sformatf("R1 priority msg %0d", i), cap_prio[d0 % 64], m[23:18]);
                chk($sformatf("R3 address msg %0d", i), req_addr[r0 % 64],
                    BASE + {15'd0, m[11:0], 5'd0});
                chk($sformatf("R7 entry msg %0d", i), cap_ent[d0 % 64],
                    entry_of(BASE + {15'd0, m[11:0], 5'd0}));
            end
        end

        // R5 R6: stall memory and fill the queue
        begin
            int accepted, d0, r0;
            accepted = 0; d0 = disp_count; r0 = req_count;
            mem_open = 1'b0;
            for (int k = 0; k < 6; k++) begin
                logic took;
                msg_data  = {20'h00005, 12'(10 + k)};
                msg_valid = 1'b1;
                took = msg_ready;
                @(negedge clk);
                if (took) accepted++;
            end
            msg_valid = 1'b0;
            chk("R5 accepted before full", accepted, 5);
            chk("R5 msg_ready low when full", msg_ready, 0);
            idle(5);
            chk("R5 msg_ready stays low", msg_ready, 0);
            chk("R6 request held", mem_req_valid, 1);
            chk("R6 held address", mem_req_addr, BASE + 32'd320);
            chk("R6 nothing granted while stalled", req_count - r0, 0);
            mem_open = 1'b1;
            idle(60);
            chk("R5 all dispatched", disp_count - d0, 5);
            for (int k = 0; k < 5; k++)
                chk($sformatf("R5 order slot %0d", k), cap_vec[(d0 + k) % 64], 12'(10 + k));
            chk("R5 msg_ready back", msg_ready, 1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule